// File: doc/BRIEF.md
# Unified Montgomery Inverse Finisher

This block closes out a modular inversion. An earlier stage, not part of this block, delivers an almost-inverse `r` together with its exponent `z`, where `r = a^-1 * 2^z mod p`. From these the finisher returns either the classical inverse or the Montgomery-domain inverse. The same datapath produces both results. Only the second operand `X` chooses between them: `X = 1` yields `a^-1 mod p`. `X = 2^(2k) mod p`, applied to an almost-inverse of a Montgomery-form operand, yields `a^-1 * 2^k mod p`.

Every result comes from a single bit-serial radix-2 Montgomery multiplier, which computes `A * B * 2^-k mod p`. When `z` equals `k`, the block runs one product, `MonPro(r, X)`. When `z` is larger, it first runs a correction product `MonPro(r, 2^(2k-z))`. The constant is built as a one-hot word. It then runs `MonPro(·, X)`. All operands are captured on the start strobe. The result is held on `result_o` and marked by a one-cycle `done_o` pulse.

Top module: `minv_finisher`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: When `z_i` equals K, the result is `r * X * 2^-K mod p`. Counting the rising edge that samples `start_i` as edge 1, `done_o` goes high just after edge K+4.
- R3: When K < `z_i` <= 2K, the result is `r * X * 2^-z mod p`. Counting as in R2, `done_o` goes high just after edge 2K+7.
- R4: Suppose `r = a^-1 * 2^z mod p`. With `X = 1`, the result is `a^-1 mod p`. Suppose instead `r = (a * 2^K)^-1 * 2^z mod p`. With `X = 2^(2K) mod p`, the result is `a^-1 * 2^K mod p`.
- R5: The result is always fully reduced, that is `result_o < p`, for every `r, X < p` and every odd K-bit `p` with its top bit set.
- R6: `done_o` is high for exactly one cycle per operation. `result_o` keeps its value until the next operation completes.
- R7: A `start_i` pulse that arrives while an operation is in progress has no effect on that operation's result or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation; operands are captured on this edge |
| r_i | input | K | Almost-inverse, below p |
| z_i | input | ZW | Exponent, K to 2K |
| x_i | input | K | Second operand: 1 or 2^(2K) mod p |
| p_i | input | K | Odd modulus with top bit set |
| result_o | output | K | Final inverse |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the multiplier accumulator at its upper bound during the correction product. This needs large `r`, a one-hot constant near the top bit (z just above K), and a modulus close to 2^(K-1). The bench reaches it by sweeping every `r` below the modulus against every legal `z`, using two moduli, one of them just above 2^(K-1). Each result is compared against a reference computed in the bench by repeated modular halving. A second campaign builds genuine almost-inverses from true inverses found by search, so that both inverse types are checked end to end.

// File: rtl/minv_pkg.sv
package minv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL1 = 2'd1,
        ST_MUL2 = 2'd2,
        ST_DONE = 2'd3
    } minv_state_e;

endpackage

// File: rtl/minv_pow2_gen.sv
module minv_pow2_gen #(
    parameter int unsigned K  = 8,
    parameter int unsigned ZW = 5
) (
    input  logic [ZW-1:0] z_i,
    output logic [K-1:0]  pow2_o
);
    localparam int unsigned IW = ZW + 1;

    logic [IW-1:0] idx;

    always_comb begin
        idx = IW'(2 * K) - IW'(z_i);
    end

    for (genvar gi = 0; gi < K; gi++) begin : g_bit
        assign pow2_o[gi] = (idx == IW'(gi));
    end

endmodule

// File: rtl/minv_mont_mul.sv
module minv_mont_mul #(
    parameter int unsigned K = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [K-1:0] a_i,
    input  logic [K-1:0] b_i,
    input  logic [K-1:0] p_i,
    output logic [K-1:0] prod_o,
    output logic         done_o
);
    localparam int unsigned AW = K + 2;
    localparam int unsigned CW = $clog2(K + 1);

    typedef struct packed {
        logic          run;
        logic          fix;
        logic [AW-1:0] acc;
        logic [K-1:0]  a_sh;
        logic [K-1:0]  b;
        logic [K-1:0]  p;
        logic [CW-1:0] cnt;
        logic [K-1:0]  prod;
        logic          done;
    } mul_regs_t;

    mul_regs_t q, d;
    logic [AW-1:0] sum;
    logic [AW-1:0] p_ext;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        p_ext = {2'b00, q.p};
        sum   = '0;
        if (q.fix) begin
            if (q.acc >= p_ext) begin
                d.prod = K'(q.acc - p_ext);
            end else begin
                d.prod = K'(q.acc);
            end
            d.done = 1'b1;
            d.fix  = 1'b0;
        end else if (q.run) begin
            sum = q.acc + (q.a_sh[0] ? {2'b00, q.b} : '0);
            if (sum[0]) begin
                sum = sum + p_ext;
            end
            d.acc  = sum >> 1;
            d.a_sh = q.a_sh >> 1;
            d.cnt  = q.cnt + 1'b1;
            if (q.cnt == CW'(K - 1)) begin
                d.run = 1'b0;
                d.fix = 1'b1;
            end
        end else if (start_i) begin
            d.run  = 1'b1;
            d.acc  = '0;
            d.a_sh = a_i;
            d.b    = b_i;
            d.p    = p_i;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign prod_o = q.prod;
    assign done_o = q.done;

    // R5: the partial sum never reaches twice the modulus
    a_r5_acc_below_2p: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.run || q.fix) |-> (q.acc < (p_ext << 1)));

    // R5: every product leaves the multiplier reduced
    a_r5_prod_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |-> ({2'b00, q.prod} < p_ext));

    // R6: completion of a product is a single-cycle event
    a_r6_mul_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |=> !q.done);

endmodule

// File: rtl/minv_finisher.sv
module minv_finisher
    import minv_pkg::*;
#(
    parameter int unsigned K = 8,
    localparam int unsigned ZW = $clog2(2 * K + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [K-1:0]  r_i,
    input  logic [ZW-1:0] z_i,
    input  logic [K-1:0]  x_i,
    input  logic [K-1:0]  p_i,
    output logic [K-1:0]  result_o,
    output logic          done_o
);
    typedef struct packed {
        minv_state_e   state;
        logic [K-1:0]  r;
        logic [ZW-1:0] z;
        logic [K-1:0]  x;
        logic [K-1:0]  p;
        logic          go;
        logic [K-1:0]  res;
        logic          done;
    } fin_regs_t;

    fin_regs_t q, d;

    logic [K-1:0] pow2;
    logic [K-1:0] mul_b;
    logic [K-1:0] mul_prod;
    logic         mul_done;

    minv_pow2_gen #(.K(K), .ZW(ZW)) pow2_i (
        .z_i    (q.z),
        .pow2_o (pow2)
    );

    always_comb begin
        mul_b = (q.state == ST_MUL1) ? pow2 : q.x;
    end

    minv_mont_mul #(.K(K)) mul_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (q.go),
        .a_i     (q.r),
        .b_i     (mul_b),
        .p_i     (q.p),
        .prod_o  (mul_prod),
        .done_o  (mul_done)
    );

    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.done = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.r  = r_i;
                    d.z  = z_i;
                    d.x  = x_i;
                    d.p  = p_i;
                    d.go = 1'b1;
                    d.state = (z_i == ZW'(K)) ? ST_MUL2 : ST_MUL1;
                end
            end
            ST_MUL1: begin
                if (mul_done) begin
                    d.r     = mul_prod;
                    d.go    = 1'b1;
                    d.state = ST_MUL2;
                end
            end
            ST_MUL2: begin
                if (mul_done) begin
                    d.res   = mul_prod;
                    d.done  = 1'b1;
                    d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign result_o = q.res;
    assign done_o   = q.done;

    // R2: exponent equal to K skips the correction product
    a_r2_skip_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_IDLE && start_i && z_i == ZW'(K)) |=> (q.state == ST_MUL2));

    // R3: the correction constant is a single set bit below K
    a_r3_onehot_const: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_MUL1) |-> ($countones(pow2) == 1));

    // R5: final result is reduced
    a_r5_result_below_p: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (result_o < q.p));

    // R6: single-cycle completion pulse, result held afterwards
    a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> (!done_o && $stable(result_o)));

    // R7: captured operands do not move while busy
    a_r7_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state != ST_IDLE && start_i) |=> ($stable(q.x) && $stable(q.p) && $stable(q.z)));

endmodule

// File: tb/minv_finisher_tb_top.sv
module minv_finisher_tb_top;
    localparam int K  = 8;
    localparam int ZW = $clog2(2 * K + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [K-1:0]  r_in;
    logic [ZW-1:0] z_in;
    logic [K-1:0]  x_in;
    logic [K-1:0]  p_in;
    logic [K-1:0]  result;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    minv_finisher #(.K(K)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .start_i  (start),
        .r_i      (r_in),
        .z_i      (z_in),
        .x_i      (x_in),
        .p_i      (p_in),
        .result_o (result),
        .done_o   (done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ref_val(longint r, longint x, longint z, longint p);
        longint v = (r * x) % p;
        for (int i = 0; i < z; i++) begin
            if (v % 2 == 1) v = (v + p) / 2;
            else            v = v / 2;
        end
        return v;
    endfunction

    function automatic longint pow2_mod(longint e, longint p);
        longint v = 1;
        for (int i = 0; i < e; i++) v = (v * 2) % p;
        return v;
    endfunction

    function automatic longint inv_of(longint a, longint p);
        for (longint b = 1; b < p; b++) begin
            if ((a * b) % p == 1) return b;
        end
        return 0;
    endfunction

    longint op_res;
    int     op_lat;

    task automatic run_op(input longint r, input longint z, input longint x, input longint p);
        @(negedge clk);
        r_in  = K'(r);
        z_in  = ZW'(z);
        x_in  = K'(x);
        p_in  = K'(p);
        start = 1'b1;
        @(posedge clk);
        op_lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done) begin
            @(posedge clk);
            #1;
            op_lat++;
        end
        op_res = longint'(result);
        @(posedge clk);
        #1;
    endtask

    task automatic sweep(input longint p, input int rstep);
        longint r2 = pow2_mod(2 * K, p);
        for (longint r = 0; r < p; r += rstep) begin
            for (longint z = K; z <= 2 * K; z++) begin
                longint x;
                case ((r + z) % 3)
                    0:       x = 1;
                    1:       x = r2;
                    default: x = (r * 7 + 3) % p;
                endcase
                run_op(r, z, x, p);
                if (z == K) begin
                    check("R2 value", op_res, ref_val(r, x, z, p));
                    check("R2 latency", op_lat, K + 4);
                end else begin
                    check("R3 value", op_res, ref_val(r, x, z, p));
                    check("R3 latency", op_lat, 2 * K + 7);
                end
                check("R5 reduced", (op_res < p) ? 1 : 0, 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        r_in  = '0;
        z_in  = ZW'(K);
        x_in  = '0;
        p_in  = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 done after reset", longint'(done), 0);
        check("R1 result after reset", longint'(result), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R5: full sweep with a modulus near 2^K
        sweep(251, 1);
        // R2 R3 R5: modulus just above 2^(K-1) stresses the accumulator bound
        sweep(131, 3);

        // R4: genuine almost-inverses, both inverse types
        for (longint a = 1; a < 24; a++) begin
            longint p   = 251;
            longint r2  = pow2_mod(2 * K, p);
            longint inv = inv_of(a, p);
            longint am  = (a * pow2_mod(K, p)) % p;
            longint ami = inv_of(am, p);
            for (longint z = K; z <= 2 * K; z += 2) begin
                run_op((inv * pow2_mod(z, p)) % p, z, 1, p);
                check("R4 classical inverse", op_res, inv);
                run_op((ami * pow2_mod(z, p)) % p, z, r2, p);
                check("R4 Montgomery inverse", op_res, (inv * pow2_mod(K, p)) % p);
            end
        end

        // R6: pulse width and hold
        run_op(100, K + 3, 1, 251);
        check("R6 done low after pulse", longint'(done), 0);
        repeat (5) @(posedge clk);
        #1;
        check("R6 result held", longint'(result), ref_val(100, 1, K + 3, 251));
        check("R6 done stays low", longint'(done), 0);

        // R7: start pulses during a busy operation are ignored
        @(negedge clk);
        r_in = K'(77); z_in = ZW'(K + 5); x_in = K'(9); p_in = K'(251);
        start = 1'b1;
        @(posedge clk);
        op_lat = 1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        r_in = K'(5); z_in = ZW'(K); x_in = K'(200); p_in = K'(131);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (K) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_lat = 1 + 2 + 1 + K + 1;
        while (!done) begin
            @(posedge clk);
            #1;
            op_lat++;
            @(negedge clk);
        end
        check("R7 value unaffected", longint'(result), ref_val(77, 9, K + 5, 251));
        @(posedge clk);
        #1;
        check("R7 no second completion", longint'(done), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule